// File: doc/BRIEF.md
# Idle-Line Multiprocessor Serial Receiver

This block receives asynchronous serial characters and sorts them into address and data characters by the gaps between them. A mark (high) line that lasts ten bit times or more after the last stop bit of a character counts as a gap. After such a gap the block halts its bit-rate tick counter and raises an idle indication. The next character to arrive is tagged as an address. Characters that arrive without a gap before them are data.

A host-owned dormant input filters delivery. While it is high, data characters are still shifted in but are thrown away, and only address characters reach the receive buffer. The host can check the address and lower the dormant input to accept the data block that follows. An error-report enable decides whether a character with a framing or parity fault is delivered with its fault flags set or is silently discarded.

Each bit time is sixteen ticks of an internal tick counter, and each tick is `DIV` clocks long. The host reads the buffer by pulsing a read strobe, which clears the ready flag.

Top module: `mpidle_uart_rx`

## Requirements
- R1: After reset, `rx_data_o` is 0, and `rx_ready_o`, `rx_addr_o`, `frame_err_o`, `parity_err_o` and `idle_o` are 0. `baud_run_o` is 1.
- R2: A character is a low start bit, then `DATA_W` data bits with the least significant bit first, then an optional parity bit when `par_en_i`=1, then the stop bits. A bit lasts 16 ticks of `DIV` clocks and is sampled at its midpoint. Parity is correct when the data bits and the parity bit together hold an even number of ones for `par_odd_i`=0, or an odd number for `par_odd_i`=1.
- R3: A low pulse that has ended before the midpoint of the start bit produces no character. It leaves the buffer and flags unchanged.
- R4: When the line stays high for at least 10 bit times after the end of the last stop bit, `idle_o` goes to 1.
- R5: `baud_run_o` falls to 0 when an idle line is detected. It returns to 1 on the next falling edge of the line.
- R6: The first character completed after an idle detection is an address and is delivered with `rx_addr_o`=1. `idle_o` clears when that character completes. A character that is not preceded by an idle detection is delivered with `rx_addr_o`=0.
- R7: While `dormant_i`=1, a data (non-address) character leaves `rx_data_o` unchanged and does not set `rx_ready_o`.
- R8: While `dormant_i`=1, an address character that is not discarded under R9 is written to `rx_data_o` and sets `rx_ready_o`.
- R9: With `err_ie_i`=0, a character that has a framing or parity error is discarded. This holds whether it is an address or data character. The buffer and all flags stay unchanged.
- R10: With `err_ie_i`=1, a character with errors is delivered. `frame_err_o` and `parity_err_o` give its faults, and both flags are loaded with every buffer write.
- R11: `dormant_i` is sampled when a character completes. If it is lowered part way through a data character, that character is delivered.
- R12: A pulse on `rd_i` clears `rx_ready_o` on the next clock and leaves the data, the address tag and the error flags unchanged. A buffer write in the same cycle wins over the read.
- R13: With `two_stop_i`=1, two stop bits are checked. A low value on either stop bit is a framing error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_i | input | 1 | Serial receive line (asynchronous) |
| two_stop_i | input | 1 | 1: two stop bits per character |
| par_en_i | input | 1 | 1: a parity bit follows the data bits |
| par_odd_i | input | 1 | 1: odd parity, 0: even parity |
| dormant_i | input | 1 | Host-owned filter: deliver address characters only |
| err_ie_i | input | 1 | 1: deliver faulty characters with flags, 0: discard them |
| rd_i | input | 1 | Host read strobe for the receive buffer |
| rx_data_o | output | DATA_W | Receive buffer |
| rx_ready_o | output | 1 | Buffer holds an unread character |
| rx_addr_o | output | 1 | Buffered character is an address |
| frame_err_o | output | 1 | Buffered character had a framing error |
| parity_err_o | output | 1 | Buffered character had a parity error |
| idle_o | output | 1 | Idle line detected; the next character is an address |
| baud_run_o | output | 1 | Tick counter running |

## Verification
The assertions assume four things about the inputs:
- `two_stop_i`, `par_en_i` and `par_odd_i` change only while the line is idle between characters.
- The line holds each bit for a full bit time.
- `rd_i` is a single-cycle pulse.
- `dormant_i` and `err_ie_i` may change at any time, because their effect is judged only at the cycle when a character completes.

The stimulus follows these rules:
- Characters are driven on exact bit-time boundaries.
- Configuration is changed only in gaps.
- Gaps are either at most two bit times, which is short of idle, or at least twelve, which is clearly idle.
- The cycle-by-cycle comparison is paused only during the last stop bit and around the idle threshold, where the exact switching cycle depends on tick alignment.

// File: rtl/mpr_pkg.sv
package mpr_pkg;
  localparam int unsigned OS_RATE = 16;
  localparam int unsigned OS_W    = $clog2(OS_RATE);
  localparam int unsigned OS_MID  = OS_RATE / 2 - 1;

  typedef enum logic [2:0] {
    FR_IDLE,
    FR_START,
    FR_DATA,
    FR_PAR,
    FR_STOP1,
    FR_STOP2
  } fr_state_e;
endpackage

// File: rtl/mpr_tick_gen.sv
module mpr_tick_gen #(
  parameter int unsigned DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic halt_i,
  output logic tick_o,
  output logic run_o
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;
  logic          run_q;

  // start realigns phase to the detected edge; it wins over halt
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      run_q <= 1'b1;
    end else if (start_i) begin
      cnt_q <= '0;
      run_q <= 1'b1;
    end else if (halt_i) begin
      run_q <= 1'b0;
    end else if (run_q) begin
      cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end
  end

  assign tick_o = run_q && (cnt_q == LAST);
  assign run_o  = run_q;
endmodule

// File: rtl/mpr_frame_rx.sv
module mpr_frame_rx
  import mpr_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_i,
  input  logic              tick_i,
  input  logic              two_stop_i,
  input  logic              par_en_i,
  input  logic              par_odd_i,
  output logic              start_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] data_o,
  output logic              fe_o,
  output logic              pe_o
);
  localparam int unsigned BC_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;

  fr_state_e         st_q;
  logic [OS_W-1:0]   os_q;
  logic [BC_W-1:0]   bc_q;
  logic [DATA_W-1:0] sh_q;
  logic              rx_q;
  logic              par_bad_q;
  logic              fe_acc_q;
  logic              fe_q;
  logic              done_q;
  logic              fall;
  logic              mid_start;
  logic              mid_bit;

  assign fall      = rx_q & ~rx_i;
  assign mid_start = tick_i && (os_q == OS_W'(OS_MID));
  assign mid_bit   = tick_i && (os_q == OS_W'(OS_RATE - 1));
  assign start_o   = (st_q == FR_IDLE) && fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= FR_IDLE;
      os_q      <= '0;
      bc_q      <= '0;
      sh_q      <= '0;
      rx_q      <= 1'b1;
      par_bad_q <= 1'b0;
      fe_acc_q  <= 1'b0;
      fe_q      <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      rx_q   <= rx_i;
      done_q <= 1'b0;
      if (tick_i && st_q != FR_IDLE) os_q <= os_q + 1'b1;
      unique case (st_q)
        FR_IDLE: begin
          if (fall) begin
            st_q <= FR_START;
            os_q <= '0;
          end
        end
        FR_START: begin
          if (mid_start) begin
            if (!rx_i) begin
              st_q      <= FR_DATA;
              os_q      <= '0;
              bc_q      <= '0;
              par_bad_q <= 1'b0;
            end else begin
              st_q <= FR_IDLE;
            end
          end
        end
        FR_DATA: begin
          if (mid_bit) begin
            sh_q <= {rx_i, sh_q[DATA_W-1:1]};
            bc_q <= bc_q + 1'b1;
            if (bc_q == BC_W'(DATA_W - 1)) st_q <= par_en_i ? FR_PAR : FR_STOP1;
          end
        end
        FR_PAR: begin
          if (mid_bit) begin
            par_bad_q <= ((^sh_q) ^ rx_i) != par_odd_i;
            st_q      <= FR_STOP1;
          end
        end
        FR_STOP1: begin
          if (mid_bit) begin
            if (two_stop_i) begin
              fe_acc_q <= ~rx_i;
              st_q     <= FR_STOP2;
            end else begin
              fe_q   <= ~rx_i;
              done_q <= 1'b1;
              st_q   <= FR_IDLE;
            end
          end
        end
        FR_STOP2: begin
          if (mid_bit) begin
            fe_q   <= fe_acc_q | ~rx_i;
            done_q <= 1'b1;
            st_q   <= FR_IDLE;
          end
        end
        default: st_q <= FR_IDLE;
      endcase
    end
  end

  assign busy_o = (st_q != FR_IDLE);
  assign done_o = done_q;
  assign data_o = sh_q;
  assign fe_o   = fe_q;
  assign pe_o   = par_bad_q;
endmodule

// File: rtl/mpr_idle_det.sv
module mpr_idle_det
  import mpr_pkg::*;
#(
  parameter int unsigned IDLE_BITS = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic line_i,
  input  logic busy_i,
  input  logic done_i,
  output logic idle_set_o,
  output logic idle_o
);
  // counted from mid of last stop bit, so add half a bit to reach its end
  localparam int unsigned IDLE_TICKS = IDLE_BITS * OS_RATE + OS_RATE / 2;
  localparam int unsigned IC_W       = $clog2(IDLE_TICKS + 1);

  logic [IC_W-1:0] cnt_q;
  logic            flag_q;
  logic            armed;

  assign armed      = !busy_i && line_i;
  assign idle_set_o = armed && tick_i && (cnt_q == IC_W'(IDLE_TICKS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (!armed) begin
      cnt_q <= '0;
    end else if (tick_i && cnt_q != IC_W'(IDLE_TICKS)) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         flag_q <= 1'b0;
    else if (idle_set_o) flag_q <= 1'b1;
    else if (done_i)     flag_q <= 1'b0;
  end

  assign idle_o = flag_q;
endmodule

// File: rtl/mpr_deliver.sv
module mpr_deliver #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              done_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              fe_i,
  input  logic              pe_i,
  input  logic              addr_i,
  input  logic              dormant_i,
  input  logic              err_ie_i,
  input  logic              rd_i,
  output logic [DATA_W-1:0] buf_o,
  output logic              ready_o,
  output logic              addr_o,
  output logic              fe_o,
  output logic              pe_o
);
  logic keep;

  assign keep = done_i && (addr_i || !dormant_i) && (!(fe_i || pe_i) || err_ie_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_o   <= '0;
      ready_o <= 1'b0;
      addr_o  <= 1'b0;
      fe_o    <= 1'b0;
      pe_o    <= 1'b0;
    end else if (keep) begin
      buf_o   <= data_i;
      ready_o <= 1'b1;
      addr_o  <= addr_i;
      fe_o    <= fe_i;
      pe_o    <= pe_i;
    end else if (rd_i) begin
      ready_o <= 1'b0;
    end
  end
endmodule

// File: rtl/mpidle_uart_rx.sv
module mpidle_uart_rx #(
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned DIV       = 4,
  parameter int unsigned IDLE_BITS = 10,
  parameter int unsigned SYNC_N    = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_i,
  input  logic              two_stop_i,
  input  logic              par_en_i,
  input  logic              par_odd_i,
  input  logic              dormant_i,
  input  logic              err_ie_i,
  input  logic              rd_i,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_ready_o,
  output logic              rx_addr_o,
  output logic              frame_err_o,
  output logic              parity_err_o,
  output logic              idle_o,
  output logic              baud_run_o
);
  logic [SYNC_N-1:0] sync_q;
  logic              line;
  logic              tick;
  logic              frm_start;
  logic              frm_busy;
  logic              frm_done;
  logic [DATA_W-1:0] frm_data;
  logic              frm_fe;
  logic              frm_pe;
  logic              idle_set;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '1;
    else         sync_q <= {sync_q[SYNC_N-2:0], rx_i};
  end
  assign line = sync_q[SYNC_N-1];

  mpr_tick_gen #(.DIV(DIV)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(frm_start),
    .halt_i (idle_set),
    .tick_o (tick),
    .run_o  (baud_run_o)
  );

  mpr_frame_rx #(.DATA_W(DATA_W)) u_frame (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rx_i      (line),
    .tick_i    (tick),
    .two_stop_i(two_stop_i),
    .par_en_i  (par_en_i),
    .par_odd_i (par_odd_i),
    .start_o   (frm_start),
    .busy_o    (frm_busy),
    .done_o    (frm_done),
    .data_o    (frm_data),
    .fe_o      (frm_fe),
    .pe_o      (frm_pe)
  );

  mpr_idle_det #(.IDLE_BITS(IDLE_BITS)) u_idle (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick),
    .line_i    (line),
    .busy_i    (frm_busy),
    .done_i    (frm_done),
    .idle_set_o(idle_set),
    .idle_o    (idle_o)
  );

  mpr_deliver #(.DATA_W(DATA_W)) u_dlv (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .done_i   (frm_done),
    .data_i   (frm_data),
    .fe_i     (frm_fe),
    .pe_i     (frm_pe),
    .addr_i   (idle_o),
    .dormant_i(dormant_i),
    .err_ie_i (err_ie_i),
    .rd_i     (rd_i),
    .buf_o    (rx_data_o),
    .ready_o  (rx_ready_o),
    .addr_o   (rx_addr_o),
    .fe_o     (frame_err_o),
    .pe_o     (parity_err_o)
  );
endmodule

// File: rtl/mpr_rx_checker.sv
module mpr_rx_checker #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              done_i,
  input logic              busy_i,
  input logic              fe_i,
  input logic              pe_i,
  input logic              dormant_i,
  input logic              err_ie_i,
  input logic              rd_i,
  input logic              idle_i,
  input logic              run_i,
  input logic              ready_i,
  input logic              frame_err_i,
  input logic [DATA_W-1:0] data_i
);
  assert_halt_on_idle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(idle_i) |-> !run_i);

  assert_restart_on_edge_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(run_i) |-> busy_i);

  assert_idle_cleared_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> !idle_i);

  assert_dormant_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && dormant_i && !idle_i) |=> ($stable(data_i) && !$rose(ready_i)));

  assert_dormant_addr_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && dormant_i && idle_i && !fe_i && !pe_i) |=> ready_i);

  assert_err_drop_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && !err_ie_i && (fe_i || pe_i)) |=> ($stable(data_i) && !$rose(ready_i)));

  assert_flag_needs_enable_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(frame_err_i) |-> $past(err_ie_i));

  assert_read_clears_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !done_i) |=> !ready_i);

  assert_ready_from_char_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ready_i) |-> $past(done_i));
endmodule

bind mpidle_uart_rx mpr_rx_checker #(.DATA_W(DATA_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .done_i     (frm_done),
  .busy_i     (frm_busy),
  .fe_i       (frm_fe),
  .pe_i       (frm_pe),
  .dormant_i  (dormant_i),
  .err_ie_i   (err_ie_i),
  .rd_i       (rd_i),
  .idle_i     (idle_o),
  .run_i      (baud_run_o),
  .ready_i    (rx_ready_o),
  .frame_err_i(frame_err_o),
  .data_i     (rx_data_o)
);

// File: tb/sim_mpidle_uart_rx.sv
module sim_mpidle_uart_rx;
  localparam int DW  = 8;
  localparam int DIV = 4;
  localparam int BIT = 16 * DIV;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx = 1'b1, two_stop = 1'b0, par_en = 1'b0, par_odd = 1'b0;
  logic dormant = 1'b0, err_ie = 1'b0, rd = 1'b0;
  logic [DW-1:0] rx_data_o;
  logic rx_ready_o, rx_addr_o, frame_err_o, parity_err_o, idle_o, baud_run_o;

  always #5 clk = ~clk;

  mpidle_uart_rx #(.DATA_W(DW), .DIV(DIV)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .rx_i(rx), .two_stop_i(two_stop),
    .par_en_i(par_en), .par_odd_i(par_odd), .dormant_i(dormant),
    .err_ie_i(err_ie), .rd_i(rd), .rx_data_o(rx_data_o),
    .rx_ready_o(rx_ready_o), .rx_addr_o(rx_addr_o), .frame_err_o(frame_err_o),
    .parity_err_o(parity_err_o), .idle_o(idle_o), .baud_run_o(baud_run_o)
  );

  int checks = 0;
  int fails = 0;
  logic [DW-1:0] e_data = '0;
  logic e_ready = 0, e_addr = 0, e_fe = 0, e_pe = 0, e_idle = 0, e_run = 1;
  bit en_buf = 1, en_idle = 1, en_run = 1;
  string cur_req = "R1";

  task automatic chk(input string req, input string nm, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", req, nm, act, exp, $time);
    end
  endtask

  // reference comparison on every clock
  always @(negedge clk) begin
    if (rst_n) begin
      if (en_buf) begin
        chk(cur_req, "rx_data_o", 32'(rx_data_o), 32'(e_data));
        chk(cur_req, "rx_ready_o", 32'(rx_ready_o), 32'(e_ready));
        chk(cur_req, "rx_addr_o", 32'(rx_addr_o), 32'(e_addr));
        chk(cur_req, "frame_err_o", 32'(frame_err_o), 32'(e_fe));
        chk(cur_req, "parity_err_o", 32'(parity_err_o), 32'(e_pe));
      end
      if (en_idle) chk("R4", "idle_o", 32'(idle_o), 32'(e_idle));
      if (en_run)  chk("R5", "baud_run_o", 32'(baud_run_o), 32'(e_run));
    end
  end

  task automatic bit_time(input logic v);
    @(posedge clk); #1 rx = v;
    repeat (BIT - 1) @(posedge clk);
  endtask

  task automatic gap(input int n);
    for (int i = 0; i < n; i++) begin
      if (i == 9) begin en_idle = 0; en_run = 0; end
      bit_time(1'b1);
    end
    if (n >= 12) begin e_idle = 1; e_run = 0; end
    en_idle = 1; en_run = 1;
  endtask

  task automatic host_read;
    @(posedge clk); #1 rd = 1'b1;
    @(posedge clk); #1 rd = 1'b0;
    e_ready = 0;
  endtask

  task automatic send_char(input logic [DW-1:0] d, input bit bad_par, input bit s1,
                           input bit s2, input bit clr_dorm_mid);
    logic fe, pe, is_addr;
    en_run = 0;
    bit_time(1'b0);
    e_run = 1; en_run = 1;
    for (int i = 0; i < DW; i++) begin
      bit_time(d[i]);
      if (i == 3 && clr_dorm_mid) #1 dormant = 1'b0;
    end
    if (par_en) bit_time((^d) ^ par_odd ^ bad_par);
    if (two_stop) begin
      bit_time(s1);
      en_buf = 0; en_idle = 0;
      bit_time(s2);
    end else begin
      en_buf = 0; en_idle = 0;
      bit_time(s1);
    end
    fe = !s1 || (two_stop && !s2);
    pe = par_en && bad_par;
    is_addr = e_idle;
    if (!(dormant && !is_addr) && (!(fe || pe) || err_ie)) begin
      e_data = d; e_ready = 1; e_addr = is_addr; e_fe = fe; e_pe = pe;
    end
    e_idle = 0;
    en_buf = 1; en_idle = 1;
  endtask

  task automatic glitch;
    en_run = 0;
    @(posedge clk); #1 rx = 1'b0;
    repeat (BIT / 4) @(posedge clk);
    #1 rx = 1'b1;
    repeat (14 * BIT) @(posedge clk);
    e_run = 0; en_run = 1;
  endtask

  initial begin
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    cur_req = "R1";
    repeat (8) @(posedge clk);
    // R4 R5: idle after reset, tick counter halts
    en_idle = 0; en_run = 0;
    repeat (13 * BIT) @(posedge clk);
    e_idle = 1; e_run = 0; en_idle = 1; en_run = 1;
    repeat (4) @(posedge clk);

    cur_req = "R6";
    send_char(8'hA5, 0, 1, 1, 0); gap(2);
    send_char(8'h3C, 0, 1, 1, 0); gap(2);
    cur_req = "R2";
    send_char(8'h01, 0, 1, 1, 0); gap(2);
    send_char(8'h80, 0, 1, 1, 0); gap(2);
    cur_req = "R12";
    host_read; repeat (4) @(posedge clk);

    cur_req = "R2";
    par_en = 1; par_odd = 0;
    send_char(8'h37, 0, 1, 1, 0); gap(2);
    par_odd = 1;
    send_char(8'h37, 0, 1, 1, 0); gap(2);
    cur_req = "R10";
    err_ie = 1;
    send_char(8'h5A, 1, 1, 1, 0); gap(2);
    host_read;
    cur_req = "R9";
    err_ie = 0;
    send_char(8'h66, 1, 1, 1, 0); gap(2);

    cur_req = "R13";
    par_en = 0; two_stop = 1; err_ie = 1;
    send_char(8'hC3, 0, 1, 0, 0); gap(2);
    send_char(8'h3C, 0, 0, 1, 0); gap(2);
    err_ie = 0;
    send_char(8'h99, 0, 1, 0, 0); gap(2);
    send_char(8'h42, 0, 1, 1, 0); gap(12);
    two_stop = 0;

    cur_req = "R8";
    dormant = 1;
    send_char(8'h11, 0, 1, 1, 0); gap(2);
    host_read;
    cur_req = "R7";
    send_char(8'h22, 0, 1, 1, 0); gap(2);
    send_char(8'h23, 0, 1, 1, 0); gap(12);
    cur_req = "R9";
    send_char(8'h33, 0, 0, 1, 0); gap(12);
    cur_req = "R8";
    send_char(8'h44, 0, 1, 1, 0); gap(2);
    cur_req = "R11";
    send_char(8'h55, 0, 1, 1, 1); gap(12);

    cur_req = "R3";
    glitch;
    cur_req = "R6";
    send_char(8'h77, 0, 1, 1, 0); gap(2);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R2 watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule